// File: doc/BRIEF.md
# ATM Cell Header Check Octet Unit

This block protects the five-octet header of a 53-octet ATM cell. It has two independent byte-wide paths. The transmit path takes a cell stream, computes an 8-bit check value over header octets one to four, and writes that value into octet five. Every other octet goes through unchanged, one clock cycle late. The receive path collects the five header octets and computes the syndrome. Depending on its current mode, it either repairs a single-bit error or rejects the cell.

The receive path has two modes, held in a state machine with two states, `MODE_CORRECT` and `MODE_DETECT`. The transitions are named as follows:

- **clean_stay**: `MODE_CORRECT` to `MODE_CORRECT` on a zero syndrome.
- **repair**: `MODE_CORRECT` to `MODE_DETECT` on a single-bit error, which is corrected.
- **reject**: `MODE_CORRECT` to `MODE_DETECT` on any other error.
- **detect_drop**: `MODE_DETECT` to `MODE_DETECT` on any error.
- **recover**: `MODE_DETECT` to `MODE_CORRECT` on a zero syndrome.

The decision is reported alongside the first payload octet (cell octet six). At that point the corrected 32-bit header is presented in parallel. Payload octets of accepted cells are then forwarded. Payload octets of rejected cells are withheld.

Each path counts octets from its start-of-cell strobe. Octets that arrive with valid high but outside a cell are ignored.

Top module: `hec_cell_unit`

## Requirements
- R1: On the transmit path, output octet five equals the remainder of (octets one to four, read as a 32-bit value with octet one most significant and each octet most-significant bit first, times x^8) modulo x^8+x^2+x+1, XORed with 0x55. The remainder starts from zero for every cell.
- R2: On the transmit path, every octet other than octet five leaves unchanged one cycle after it enters. `tx_out_valid` and `tx_out_sop` follow the input strobes with the same one-cycle delay.
- R3: After reset the receive path is in correction mode (`rx_detect_mode` = 0), and both output valids are low.
- R4: A received header whose syndrome is zero is accepted. One cycle after the first payload octet enters, `rx_out_first` and `rx_accept` are high, `rx_corrected` is low, and `rx_hdr` carries octets one to four.
- R5: In correction mode, a single-bit error in any of the 40 header bit positions is repaired. `rx_accept` and `rx_corrected` are high, `rx_hdr` holds the original octets, and the mode becomes detection.
- R6: In correction mode, an error that is not a single-bit error discards the cell (`rx_discard` high) and moves to detection mode.
- R7: In detection mode, any header with a nonzero syndrome, including a single-bit one, is discarded and the mode stays detection.
- R8: In detection mode, an error-free header is accepted and returns the receiver to correction mode.
- R9: For accepted cells, payload octets six to 53 appear on `rx_out_data` with `rx_out_valid` high, one cycle after entry. For discarded cells, `rx_out_valid` stays low for the whole payload.
- R10: Each received cell produces exactly one of `rx_accept` or `rx_discard`, in the cycle where `rx_out_first` is high. `rx_corrected` is only ever high together with `rx_accept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Transmit octet strobe |
| tx_in_sop | input | 1 | Marks octet one of a transmit cell |
| tx_in_data | input | 8 | Transmit octet |
| tx_out_valid | output | 1 | Transmit output octet strobe |
| tx_out_sop | output | 1 | Marks output octet one |
| tx_out_data | output | 8 | Transmit octet with check octet inserted |
| rx_in_valid | input | 1 | Receive octet strobe |
| rx_in_sop | input | 1 | Marks octet one of a received cell |
| rx_in_data | input | 8 | Received octet |
| rx_out_valid | output | 1 | Forwarded payload octet strobe |
| rx_out_data | output | 8 | Forwarded payload octet |
| rx_out_first | output | 1 | High with the cell's first payload position |
| rx_hdr | output | 32 | Corrected header octets one to four |
| rx_accept | output | 1 | Cell accepted |
| rx_corrected | output | 1 | Header was repaired |
| rx_discard | output | 1 | Cell discarded |
| rx_detect_mode | output | 1 | 1 when the receiver is in detection mode |

## Verification
The bench uses the default parameters: 53-octet cells, generator 0x07 and coset 0x55. With these values the header is only 40 bits, so every single-bit error position can be swept in both modes. Double-bit errors are injected at 40 distinct position pairs. A double error always yields an even-weight syndrome that cannot alias a single-bit one, so every such cell has a known discard verdict. Transmit check octets are compared against a 40-bit long division carried out in the bench, over walking-one headers and mixed patterns.

// File: rtl/hec_pkg.sv
package hec_pkg;

    localparam int HDR_OCTETS = 5;
    localparam int HDR_BITS   = HDR_OCTETS * 8;

    typedef enum logic {
        MODE_CORRECT = 1'b0,
        MODE_DETECT  = 1'b1
    } rx_mode_e;

    // One serial division step, most significant bit first
    function automatic logic [7:0] crc8_bit(input logic [7:0] r, input logic d,
                                            input logic [7:0] poly);
        logic fb;
        fb = r[7] ^ d;
        return {r[6:0], 1'b0} ^ (fb ? poly : 8'h00);
    endfunction

    function automatic logic [7:0] crc8_byte(input logic [7:0] r, input logic [7:0] b,
                                             input logic [7:0] poly);
        logic [7:0] acc;
        acc = r;
        for (int i = 7; i >= 0; i--) acc = crc8_bit(acc, b[i], poly);
        return acc;
    endfunction

    function automatic logic [7:0] crc8_word(input logic [31:0] w, input logic [7:0] poly);
        logic [7:0] acc;
        acc = 8'h00;
        for (int i = 31; i >= 0; i--) acc = crc8_bit(acc, w[i], poly);
        return acc;
    endfunction

    // Syndrome produced by a lone flipped bit at header position pos (0 = last HEC bit)
    function automatic logic [7:0] single_syn(input int pos, input logic [7:0] poly);
        if (pos < 8) return 8'(1) << pos;
        return crc8_word(32'(1) << (pos - 8), poly);
    endfunction

endpackage

// File: rtl/hec_octet_ctr.sv
module hec_octet_ctr #(
    parameter int CELL_OCTETS = 53,
    localparam int IW = $clog2(CELL_OCTETS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sop,
    output logic [IW-1:0] idx,
    output logic          take
);
    localparam logic [IW-1:0] IDLE = IW'(CELL_OCTETS);

    logic [IW-1:0] cnt_q;

    always_comb begin
        idx  = in_sop ? '0 : cnt_q;
        take = in_valid && (in_sop || (cnt_q != IDLE));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= IDLE;
        end else if (take) begin
            cnt_q <= idx + IW'(1);
        end
    end

endmodule

// File: rtl/hec_tx_gen.sv
module hec_tx_gen #(
    parameter int         CELL_OCTETS = 53,
    parameter logic [7:0] POLY        = 8'h07,
    parameter logic [7:0] COSET       = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic [7:0] in_data,
    output logic       out_valid,
    output logic       out_sop,
    output logic [7:0] out_data
);
    localparam int IW = $clog2(CELL_OCTETS + 1);
    localparam logic [IW-1:0] HEC_IDX = IW'(hec_pkg::HDR_OCTETS - 1);

    logic [IW-1:0] idx;
    logic          take;
    logic [7:0]    crc_q;
    logic          valid_q;
    logic          sop_q;
    logic [7:0]    data_q;

    hec_octet_ctr #(.CELL_OCTETS(CELL_OCTETS)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .idx      (idx),
        .take     (take)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q   <= '0;
            valid_q <= 1'b0;
            sop_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= take;
            sop_q   <= take && (idx == '0);
            if (take) begin
                if (idx < HEC_IDX) begin
                    crc_q <= hec_pkg::crc8_byte((idx == '0) ? 8'h00 : crc_q, in_data, POLY);
                end
                data_q <= (idx == HEC_IDX) ? (crc_q ^ COSET) : in_data;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_sop   = sop_q;
    assign out_data  = data_q;

endmodule

// File: rtl/hec_mode_fsm.sv
module hec_mode_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic eval,
    input  logic syn_zero,
    input  logic syn_single,
    output logic v_accept,
    output logic v_fix,
    output logic v_drop,
    output logic detect_mode
);
    import hec_pkg::*;

    rx_mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_CORRECT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_CORRECT: if (eval && !syn_zero) state_d = MODE_DETECT;  // repair / reject
            MODE_DETECT:  if (eval && syn_zero)  state_d = MODE_CORRECT; // recover
            default:      state_d = MODE_CORRECT;
        endcase
    end

    // verdict outputs
    always_comb begin
        v_accept = 1'b0;
        v_fix    = 1'b0;
        v_drop   = 1'b0;
        unique case (state_q)
            MODE_CORRECT: begin
                v_accept = eval && (syn_zero || syn_single);
                v_fix    = eval && !syn_zero && syn_single;
                v_drop   = eval && !syn_zero && !syn_single;
            end
            MODE_DETECT: begin
                v_accept = eval && syn_zero;
                v_drop   = eval && !syn_zero;
            end
            default: ;
        endcase
    end

    assign detect_mode = (state_q == MODE_DETECT);

endmodule

// File: rtl/hec_rx_check.sv
module hec_rx_check #(
    parameter int         CELL_OCTETS = 53,
    parameter logic [7:0] POLY        = 8'h07,
    parameter logic [7:0] COSET       = 8'h55
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic [7:0]  in_data,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_first,
    output logic [31:0] hdr,
    output logic        accept,
    output logic        corrected,
    output logic        discard,
    output logic        detect_mode
);
    localparam int NB = hec_pkg::HDR_BITS;
    localparam int IW = $clog2(CELL_OCTETS + 1);
    localparam logic [IW-1:0] PAY_IDX = IW'(hec_pkg::HDR_OCTETS);

    logic [IW-1:0] idx;
    logic          take;
    logic          eval;
    logic [NB-1:0] hdr_q;
    logic [7:0]    syn;
    logic [NB-1:0] hit;
    logic [NB-1:0] fixed;
    logic          v_accept, v_fix, v_drop;
    logic          dropping_q;
    logic          valid_q, first_q, acc_q, fix_q, drop_q;
    logic [7:0]    data_q;
    logic [31:0]   hdr_out_q;

    hec_octet_ctr #(.CELL_OCTETS(CELL_OCTETS)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .idx      (idx),
        .take     (take)
    );

    assign eval = take && (idx == PAY_IDX);

    // syndrome with the coset removed from the received check octet
    assign syn = hec_pkg::crc8_word(hdr_q[NB-1:8], POLY) ^ hdr_q[7:0] ^ COSET;

    for (genvar p = 0; p < NB; p++) begin : g_syn
        localparam logic [7:0] SYN_P = hec_pkg::single_syn(p, POLY);
        assign hit[p] = (syn == SYN_P);
    end

    assign fixed = hdr_q ^ hit;

    hec_mode_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .eval        (eval),
        .syn_zero    (syn == 8'h00),
        .syn_single  (|hit),
        .v_accept    (v_accept),
        .v_fix       (v_fix),
        .v_drop      (v_drop),
        .detect_mode (detect_mode)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q      <= '0;
            dropping_q <= 1'b0;
            valid_q    <= 1'b0;
            first_q    <= 1'b0;
            acc_q      <= 1'b0;
            fix_q      <= 1'b0;
            drop_q     <= 1'b0;
            data_q     <= '0;
            hdr_out_q  <= '0;
        end else begin
            if (take && (idx < PAY_IDX)) hdr_q <= {hdr_q[NB-9:0], in_data};
            if (take && (idx == '0))     dropping_q <= 1'b0;
            else if (eval)               dropping_q <= v_drop;
            valid_q <= take && (idx >= PAY_IDX) && !(eval ? v_drop : dropping_q);
            first_q <= eval;
            acc_q   <= v_accept;
            fix_q   <= v_fix;
            drop_q  <= v_drop;
            if (take)     data_q    <= in_data;
            if (v_accept) hdr_out_q <= fixed[NB-1:8];
        end
    end

    assign out_valid = valid_q;
    assign out_data  = data_q;
    assign out_first = first_q;
    assign hdr       = hdr_out_q;
    assign accept    = acc_q;
    assign corrected = fix_q;
    assign discard   = drop_q;

endmodule

// File: rtl/hec_cell_unit.sv
module hec_cell_unit #(
    parameter int         CELL_OCTETS = 53,
    parameter logic [7:0] POLY        = 8'h07,
    parameter logic [7:0] COSET       = 8'h55
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_in_valid,
    input  logic        tx_in_sop,
    input  logic [7:0]  tx_in_data,
    output logic        tx_out_valid,
    output logic        tx_out_sop,
    output logic [7:0]  tx_out_data,
    input  logic        rx_in_valid,
    input  logic        rx_in_sop,
    input  logic [7:0]  rx_in_data,
    output logic        rx_out_valid,
    output logic [7:0]  rx_out_data,
    output logic        rx_out_first,
    output logic [31:0] rx_hdr,
    output logic        rx_accept,
    output logic        rx_corrected,
    output logic        rx_discard,
    output logic        rx_detect_mode
);

    hec_tx_gen #(.CELL_OCTETS(CELL_OCTETS), .POLY(POLY), .COSET(COSET)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_in_valid),
        .in_sop    (tx_in_sop),
        .in_data   (tx_in_data),
        .out_valid (tx_out_valid),
        .out_sop   (tx_out_sop),
        .out_data  (tx_out_data)
    );

    hec_rx_check #(.CELL_OCTETS(CELL_OCTETS), .POLY(POLY), .COSET(COSET)) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (rx_in_valid),
        .in_sop      (rx_in_sop),
        .in_data     (rx_in_data),
        .out_valid   (rx_out_valid),
        .out_data    (rx_out_data),
        .out_first   (rx_out_first),
        .hdr         (rx_hdr),
        .accept      (rx_accept),
        .corrected   (rx_corrected),
        .discard     (rx_discard),
        .detect_mode (rx_detect_mode)
    );

endmodule

// File: rtl/hec_cell_unit_chk.sv
module hec_cell_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_in_valid,
    input logic tx_in_sop,
    input logic tx_out_valid,
    input logic tx_out_sop,
    input logic rx_out_valid,
    input logic rx_out_first,
    input logic rx_accept,
    input logic rx_corrected,
    input logic rx_discard,
    input logic rx_detect_mode
);

    AST_TX_SOP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && tx_in_sop) |=> (tx_out_valid && tx_out_sop)); // R2

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_first |-> $onehot({rx_accept, rx_discard})); // R10

    AST_VERDICT_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_accept || rx_discard) |-> rx_out_first); // R10

    AST_FIX_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_corrected |-> rx_accept); // R10

    AST_FIX_ENTERS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_corrected |-> rx_detect_mode); // R5

    AST_DROP_IN_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_discard |-> rx_detect_mode); // R6

    AST_DROP_STAYS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_discard && $past(rx_detect_mode)) |-> rx_detect_mode); // R7

    AST_CLEAN_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_accept && !rx_corrected) |-> !rx_detect_mode); // R8

    AST_DROP_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_discard |-> !rx_out_valid); // R9

endmodule

bind hec_cell_unit hec_cell_unit_chk chk_i (.*);

// File: tb/hec_cell_unit_tb_top.sv
module hec_cell_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CELL = 53;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_in_valid = 1'b0, tx_in_sop = 1'b0;
    logic [7:0]  tx_in_data = '0;
    logic        tx_out_valid, tx_out_sop;
    logic [7:0]  tx_out_data;
    logic        rx_in_valid = 1'b0, rx_in_sop = 1'b0;
    logic [7:0]  rx_in_data = '0;
    logic        rx_out_valid, rx_out_first, rx_accept, rx_corrected, rx_discard, rx_detect_mode;
    logic [7:0]  rx_out_data;
    logic [31:0] rx_hdr;

    int vectors = 0;
    int miscompares = 0;
    logic bmode = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hec_cell_unit dut_i (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // long division of the 40-bit header polynomial, coset added afterwards
    function automatic logic [7:0] hec_of(input logic [31:0] h);
        logic [39:0] v;
        v = {h, 8'h00};
        for (int i = 39; i >= 8; i--)
            if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h107;
        return v[7:0] ^ 8'h55;
    endfunction

    function automatic logic [7:0] pay(input int seed, input int k);
        return 8'(seed * 7 + k * 29 + 3);
    endfunction

    task automatic tx_cell(input logic [31:0] h, input int seed);
        logic [39:0] w;
        w = {h, hec_of(h)};
        for (int k = 0; k <= CELL; k++) begin
            @(negedge clk);
            if (k > 0) begin
                int j = k - 1;
                logic [7:0] e = (j < 5) ? w[39 - 8*j -: 8] : pay(seed, j);
                chk((j == 4) ? "R1 check octet" : "R2 passthrough", {56'h0, tx_out_data}, {56'h0, e});
                chk("R2 valid/sop", {62'h0, tx_out_valid, tx_out_sop}, {62'h0, 1'b1, j == 0});
            end
            tx_in_valid = (k < CELL);
            tx_in_sop   = (k == 0);
            tx_in_data  = (k < 4) ? h[31 - 8*k -: 8] : (k == 4 ? 8'hA5 : pay(seed, k));
        end
        tx_in_valid = 1'b0;
        tx_in_sop   = 1'b0;
    endtask

    task automatic rx_cell(input logic [31:0] h, input logic [39:0] err, input int seed);
        logic [39:0] w;
        int wt;
        logic ex_acc, ex_fix;
        w  = {h, hec_of(h)} ^ err;
        wt = $countones(err);
        if (!bmode) begin
            ex_acc = (wt <= 1); ex_fix = (wt == 1); bmode = (wt != 0);
        end else begin
            ex_acc = (wt == 0); ex_fix = 1'b0; bmode = (wt != 0);
        end
        for (int k = 0; k <= CELL; k++) begin
            @(negedge clk);
            if (k > 0) begin
                int j = k - 1;
                if (j == 5) begin
                    chk("R10 first", {63'h0, rx_out_first}, 64'h1);
                    chk(wt == 0 ? "R4 accept" : (ex_fix ? "R5 accept" : "R6 R7 discard"),
                        {62'h0, rx_accept, rx_discard}, {62'h0, ex_acc, !ex_acc});
                    chk(ex_fix ? "R5 corrected" : "R10 corrected", {63'h0, rx_corrected}, {63'h0, ex_fix});
                    chk(bmode ? "R6 R7 mode" : "R8 mode", {63'h0, rx_detect_mode}, {63'h0, bmode});
                    if (ex_acc) chk(ex_fix ? "R5 header" : "R4 header", {32'h0, rx_hdr}, {32'h0, h});
                end else begin
                    chk("R10 no verdict", {61'h0, rx_out_first, rx_accept, rx_discard}, 64'h0);
                end
                chk("R9 valid", {63'h0, rx_out_valid}, {63'h0, (j >= 5) && ex_acc});
                if (j >= 5 && ex_acc) chk("R9 payload", {56'h0, rx_out_data}, {56'h0, pay(seed, j)});
            end
            rx_in_valid = (k < CELL);
            rx_in_sop   = (k == 0);
            rx_in_data  = (k < 5) ? w[39 - 8*k -: 8] : pay(seed, k);
        end
        rx_in_valid = 1'b0;
        rx_in_sop   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset mode", {63'h0, rx_detect_mode}, 64'h0);
        chk("R3 reset valids", {62'h0, tx_out_valid, rx_out_valid}, 64'h0);

        // transmit sweep
        tx_cell(32'h0, 1);
        tx_cell(32'hFFFF_FFFF, 2);
        for (int b = 0; b < 32; b++) tx_cell(32'(1) << b, b + 3);
        for (int i = 0; i < 8; i++) tx_cell(32'(i) * 32'h9E37_79B9 + 32'h0123_4567, i + 40);

        // receive: clean, single-bit sweep in both modes, recovery
        rx_cell(32'h0012_3450, 40'h0, 5);
        for (int p = 0; p < 40; p++) begin
            logic [31:0] h = 32'(p) * 32'h0101_0103 + 32'h5A00_0F0F;
            rx_cell(h, 40'(1) << p, p);                    // R5 repair
            rx_cell(h ^ 32'h1, 40'(1) << ((p + 7) % 40), p + 1); // R7 single in detect
            rx_cell(h, 40'h0, p + 2);                      // R8 recover
        end
        // double-bit errors in both modes
        for (int p = 0; p < 40; p++) begin
            logic [39:0] e = (40'(1) << p) | (40'(1) << ((p + 13) % 40));
            logic [31:0] h = 32'(p) * 32'h1357_9BDF;
            rx_cell(h, e, p + 3);                          // R6
            rx_cell(h, e, p + 4);                          // R7
            rx_cell(h, 40'h0, p + 5);                      // R8
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule